// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. While the active-low load control is held low, every stage of the register copies its own parallel input, and keeps copying it for as long as the control stays low. Once the control returns high, the register is frozen at the last word it copied. From then on it can only shift. The last stage drives a true output and an inverted output, so a receiver takes the word most significant stage first.

Shifting is clocked by a two-input gate: the shift edge is the rising edge of the OR of the two clock inputs. Either input can therefore act as the clock, with the other held low. Holding either input high blocks all shifting, which makes that input a clock inhibit. On every shift edge the serial input enters the first stage and each other stage takes the value of the stage before it.

The block fits wherever a byte-wide source must be streamed out over one wire, for example when reading a bank of switches or chaining several registers through their serial inputs.

Top module: `psr_serializer`

## Requirements
- R1: The register has WIDTH stages. Bit 0 of `par_in` feeds the first stage and bit WIDTH-1 feeds the last stage. `q_out` always shows the last stage.
- R2: While `load_n` is low, every stage follows its bit of `par_in` continuously. Changes on `par_in` appear at once, whatever `clk_a`, `clk_b` and `ser_in` are doing.
- R3: With `load_n` high, each rising edge of `clk_a | clk_b` does two things: it moves `ser_in` into the first stage, and it moves each stage i (i ≥ 1) the value of stage i-1.
- R4: With `clk_b` held high, transitions on `clk_a` leave every stage unchanged.
- R5: With `clk_a` held low, rising edges of `clk_b` shift the register exactly as rising edges of `clk_a` do.
- R6: When `load_n` rises, the register keeps the last word it copied. Later changes on `par_in` have no effect while `load_n` stays high.
- R7: `q_out_n` is always the inverse of `q_out`.
- R8: An input used as the inhibit may rise only while the other input, the running clock, is high. Otherwise the rising inhibit would itself create a shift edge.
- R9: Clock edges that arrive while `load_n` is low do not shift. After release, the register holds the parallel word, not a shifted one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock input; can also act as the inhibit |
| clk_b | input | 1 | Clock input; can also act as the inhibit |
| load_n | input | 1 | Active-low level-sensitive parallel load |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | WIDTH | Parallel data, bit 0 to the first stage |
| q_out | output | 1 | Last stage, true |
| q_out_n | output | 1 | Last stage, inverted |

## Verification
The bench builds the block with its default WIDTH of 8. At that width the whole register can be drained through `q_out` in eight edges, so every value the register holds after a load, after an inhibited burst or after release can be read back completely. A second drain of eight edges shows the serial bits that were shifted in. The bench drives the clock from each input in turn and uses the other as the inhibit. It monitors its own stimulus for an inhibit that rises while the clock is low.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Which storage the visible stages come from.
  typedef enum logic {
    SRC_HELD  = 1'b0,
    SRC_SHIFT = 1'b1
  } src_e;

endpackage

// File: rtl/psr_clk_gate.sv
module psr_clk_gate (
  input  logic clk_a,
  input  logic clk_b,
  output logic gclk
);
  logic gate_nor;

  // NOR of both inputs; the shift edge is the rising edge of its inverse.
  assign gate_nor = ~(clk_a | clk_b);
  assign gclk     = ~gate_nor;
endmodule

// File: rtl/psr_load_hold.sv
module psr_load_hold #(
  parameter int WIDTH = 8
) (
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] held
);
  // Transparent while load_n is low, frozen when it rises.
  always_latch begin
    if (!load_n) held = par_in;
  end
endmodule

// File: rtl/psr_shift_core.sv
module psr_shift_core #(
  parameter int WIDTH = 8
) (
  input  logic             gclk,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] stage
);
  import psr_pkg::*;

  src_e             src_q;
  logic [WIDTH-1:0] shreg_q;
  logic [WIDTH-1:0] next_vec;

  // Cleared by the load level, set by the first shift edge after release.
  always_ff @(posedge gclk or negedge load_n) begin
    if (!load_n) src_q <= SRC_HELD;
    else         src_q <= SRC_SHIFT;
  end

  assign stage = (src_q == SRC_SHIFT) ? shreg_q : held;

  for (genvar i = 0; i < WIDTH; i++) begin : g_next
    if (i == 0) begin : g_first
      assign next_vec[i] = ser_in;
    end else begin : g_rest
      assign next_vec[i] = stage[i-1];
    end
  end

  always_ff @(posedge gclk) begin
    if (load_n) shreg_q <= next_vec;
  end
endmodule

// File: rtl/psr_serializer.sv
module psr_serializer #(
  parameter int WIDTH = 8
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_out,
  output logic             q_out_n
);
  localparam int LAST = WIDTH - 1;

  logic             gclk;
  logic [WIDTH-1:0] held_vec;
  logic [WIDTH-1:0] stage_vec;

  psr_clk_gate u_gate (
    .clk_a (clk_a),
    .clk_b (clk_b),
    .gclk  (gclk)
  );

  psr_load_hold #(.WIDTH(WIDTH)) u_hold (
    .load_n (load_n),
    .par_in (par_in),
    .held   (held_vec)
  );

  psr_shift_core #(.WIDTH(WIDTH)) u_core (
    .gclk   (gclk),
    .load_n (load_n),
    .ser_in (ser_in),
    .held   (held_vec),
    .stage  (stage_vec)
  );

  assign q_out   = stage_vec[LAST];
  assign q_out_n = ~stage_vec[LAST];
endmodule

// File: rtl/psr_serializer_chk.sv
module psr_serializer_chk #(
  parameter int WIDTH = 8
) (
  input logic             gclk,
  input logic             load_n,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_vec,
  input logic             q_out,
  input logic             q_out_n
);
  logic             armed = 1'b0;
  logic             rel_seen = 1'b0;
  logic [WIDTH-1:0] exp_q = '0;
  logic [WIDTH-1:0] rel_q = '0;

  always_ff @(posedge gclk or negedge load_n) begin
    if (!load_n) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always_ff @(posedge gclk) exp_q <= {stage_vec[WIDTH-2:0], ser_in};

  always_ff @(posedge load_n) begin
    rel_q    <= par_in;
    rel_seen <= 1'b1;
  end

  p_shift_r3: assert property (@(negedge gclk) disable iff (!load_n)
    armed |-> stage_vec == exp_q);

  p_out_pair_r7: assert property (@(negedge gclk) disable iff (!load_n)
    armed |-> (q_out == exp_q[WIDTH-1]) && (q_out_n == !exp_q[WIDTH-1]));

  p_load_track_r2: assert property (@(posedge load_n)
    stage_vec == par_in);

  p_hold_release_r6: assert property (@(posedge gclk) disable iff (!load_n)
    (rel_seen && !armed) |-> stage_vec == rel_q);
endmodule

bind psr_serializer psr_serializer_chk #(.WIDTH(WIDTH)) u_chk (
  .gclk      (gclk),
  .load_n    (load_n),
  .ser_in    (ser_in),
  .par_in    (par_in),
  .stage_vec (stage_vec),
  .q_out     (q_out),
  .q_out_n   (q_out_n)
);

// File: tb/test_psr_serializer.sv
module test_psr_serializer;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;
  localparam int W     = 8;

  logic         clk_a, clk_b, load_n, ser_in;
  logic [W-1:0] par_in;
  logic         q_out, q_out_n;
  logic         b_is_inh;
  logic [W-1:0] m;
  int           total = 0;
  int           bad   = 0;

  psr_serializer #(.WIDTH(W)) i_psr_serializer (
    .clk_a, .clk_b, .load_n, .ser_in, .par_in, .q_out, .q_out_n
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: inhibit on clk_b may only rise while clk_a is high
  always @(posedge clk_b) begin
    if (b_is_inh) begin
      total++;
      if (clk_a !== 1'b1) begin
        bad++;
        $display("FAIL R8 actual clk_a=%b expected=1", clk_a);
      end
    end
  end

  task automatic pulse(input logic use_b, input logic s);
    ser_in = s;
    #HALF;
    if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
    #HALF;
    if (use_b) clk_b = 1'b0; else clk_a = 1'b0;
  endtask

  // Drains the model word through q_out, shifting in the given bits.
  task automatic drain(input string req, input logic use_b, input logic [W-1:0] sin);
    for (int k = 0; k < W; k++) begin
      #1;
      check(req, {{(W-1){1'b0}}, q_out}, {{(W-1){1'b0}}, m[W-1]});
      check("R7", {{(W-1){1'b0}}, q_out_n}, {{(W-1){1'b0}}, ~m[W-1]});
      pulse(use_b, sin[k]);
      m = {m[W-2:0], sin[k]};
    end
  endtask

  task automatic load_word(input logic [W-1:0] v);
    load_n = 1'b0; par_in = v; #CLK_P;
    load_n = 1'b1; #CLK_P;
    m = v;
  endtask

  task automatic t_reset_state;
    par_in = 8'hA5; #CLK_P;
    check("R1 first load", {7'b0, q_out}, 8'h01);
    check("R7 first load", {7'b0, q_out_n}, 8'h00);
  endtask

  task automatic t_load_track;
    load_n = 1'b0; par_in = 8'h3C; #1;
    check("R2 track", {7'b0, q_out}, 8'h00);
    par_in = 8'hC3; #1;
    check("R2 track", {7'b0, q_out}, 8'h01);
    pulse(1'b0, 1'b0); pulse(1'b0, 1'b0); #1;
    check("R9 edges during load", {7'b0, q_out}, 8'h01);
    load_n = 1'b1; #CLK_P;
    m = 8'hC3;
    drain("R9 word after release", 1'b0, 8'h00);
  endtask

  task automatic t_shift_random;
    for (int n = 0; n < 6; n++) begin
      logic [W-1:0] v, s;
      v = W'($urandom);
      s = W'($urandom);
      load_word(v);
      drain("R3 shift out", 1'b0, s);
      drain("R3 serial in", 1'b0, 8'h00);
    end
  endtask

  task automatic t_inhibit;
    load_n = 1'b0; par_in = 8'h96; #1;
    clk_a = 1'b1; #HALF;
    load_n = 1'b1; #HALF;
    clk_b = 1'b1; #HALF;
    for (int k = 0; k < 4; k++) begin
      ser_in = k[0];
      clk_a = 1'b0; #HALF;
      clk_a = 1'b1; #HALF;
    end
    clk_b = 1'b0; #HALF;
    clk_a = 1'b0; #HALF;
    m = 8'h96;
    drain("R4 inhibited", 1'b0, 8'h00);
  endtask

  task automatic t_swap;
    load_word(8'h5A);
    b_is_inh = 1'b0;
    drain("R5 clock on b", 1'b1, 8'b1100_1010);
    drain("R5 serial in on b", 1'b1, 8'h00);
    b_is_inh = 1'b1;
  endtask

  task automatic t_release_hold;
    load_n = 1'b0; par_in = 8'hF0; #CLK_P;
    load_n = 1'b1; #1;
    par_in = 8'h0F; #CLK_P;
    m = 8'hF0;
    drain("R6 held word", 1'b0, 8'h00);
  endtask

  initial begin
    clk_a = 1'b0; clk_b = 1'b0; load_n = 1'b0; ser_in = 1'b0;
    par_in = '0; b_is_inh = 1'b1; m = '0;
    t_reset_state();
    t_load_track();
    t_shift_random();
    t_inhibit();
    t_swap();
    t_release_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule